// File: doc/BRIEF.md
# Two-Wire Start Detector and Clock Holder

This block sits beside the shift register and bit counter of a small serial engine when that engine runs in two-wire (I2C-style) mode. It samples the open-drain data and clock lines through synchroniser chains and watches for a start condition. A start sets a sticky start flag, which can raise an interrupt, and emits a one-cycle pulse that clears the bit counter so the next byte is counted from zero.

The block can stretch the bus clock by pulling the clock line low. It holds the clock after a start, once the master has taken the clock low. It can also hold it while the counter-overflow flag is set, and this second hold can be switched off. Software ends a hold by writing one to clear the matching flag. The clock hold and the engine's own clock drive share one open-drain output, so either source can pull the line low. The data line is pulled low whenever the most significant bit of the shift register is zero.

The two-wire bus clock must stay at or below one sixteenth of the system clock. At that rate the synchroniser delay stays well inside one bus phase.

Top module: `twsh_top`

## Requirements
- R1: With the default two synchroniser stages, a falling edge on `sda_in` while `scl_in` is high is a start condition. If the inputs change just before clock edge k, `start_flag` reads 1 after edge k+2.
- R2: `cnt_reset` is high for exactly one cycle on each start condition. That cycle is the one just before `start_flag` rises, between edges k+1 and k+2.
- R3: When `clr_start` is high at a clock edge, `start_flag` and the start hold both clear at that edge. If a start condition falls in the same cycle, `start_flag` is set (set has priority over clear).
- R4: After `start_flag` is set and synchronised `scl_in` is seen low, `scl_pull_low` stays at 1 until `clr_start`. While `scl_in` stays high after the start, the start hold does not engage.
- R5: A one-cycle `cnt_ovf` pulse sets `ovf_flag` at the next edge. `clr_ovf` clears it, and if `cnt_ovf` and `clr_ovf` are high in the same cycle the flag is set.
- R6: While `ovf_flag` is 1 and `ovf_hold_en` is 1, `scl_pull_low` is 1. When `ovf_hold_en` is 0, the overflow flag does not hold the clock.
- R7: `irq` is 1 exactly when (`start_flag` and `start_ie`) or (`ovf_flag` and `ovf_ie`).
- R8: `scl_pull_low` is the OR of the hold request and `scl_data_low`, so either source pulls the line low. With no flag set and `scl_data_low` at 0, it is 0.
- R9: `sda_pull_low` is 1 exactly when `shift_msb` is 0. The output is open-drain, so a 1 bit releases the line.
- R10: A falling edge on `sda_in` while `scl_in` is low does not set `start_flag`, and neither does a rising edge on `sda_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Sensed level of the data line |
| scl_in | input | 1 | Sensed level of the clock line |
| shift_msb | input | 1 | Most significant bit of the shift register |
| scl_data_low | input | 1 | Clock-line pull request from the data path |
| cnt_ovf | input | 1 | One-cycle bit-counter overflow pulse |
| clr_start | input | 1 | Write-one clear of the start flag and start hold |
| clr_ovf | input | 1 | Write-one clear of the overflow flag |
| start_ie | input | 1 | Start interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| ovf_hold_en | input | 1 | Enables clock holding on overflow |
| start_flag | output | 1 | Sticky start-detected flag |
| ovf_flag | output | 1 | Sticky counter-overflow flag |
| irq | output | 1 | Interrupt request |
| cnt_reset | output | 1 | One-cycle bit-counter clear on start |
| scl_pull_low | output | 1 | Open-drain clock drive, 1 pulls the line low |
| sda_pull_low | output | 1 | Open-drain data drive, 1 pulls the line low |

## Verification
Two pairs of events can land in the same cycle: a start condition and the software clear of the start flag, and a counter overflow and the clear of the overflow flag. The bench drives the data line low and times `clr_start` so that it is high in exactly the cycle where `cnt_reset` pulses. It also pulses `cnt_ovf` and `clr_ovf` together. In both cases the flag must read 1 afterwards. A random sequence of line levels, with occasional clears, then checks the start flag and the clock hold against a step-level model.

// File: rtl/twsh_pkg.sv
package twsh_pkg;

    // One sample of the two bus lines
    typedef struct packed {
        logic sda;
        logic scl;
    } bus_lines_t;

    // Idle bus level: both lines released high
    localparam bus_lines_t BUS_IDLE = '{sda: 1'b1, scl: 1'b1};

    // Start: data falls while the clock is high in the newer sample
    function automatic logic is_start(input bus_lines_t older, input bus_lines_t newer);
        return older.sda & ~newer.sda & newer.scl;
    endfunction

endpackage

// File: rtl/twsh_sync.sv
module twsh_sync
    import twsh_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_lines_t raw,
    output bus_lines_t synced
);
    bus_lines_t chain [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[g] <= BUS_IDLE;
                end else if (g == 0) begin
                    chain[g] <= raw;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign synced = chain[STAGES-1];
endmodule

// File: rtl/twsh_start_det.sv
module twsh_start_det
    import twsh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_lines_t synced,
    output logic       start_evt
);
    bus_lines_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= BUS_IDLE;
        else     prev_q <= synced;
    end

    assign start_evt = is_start(prev_q, synced);
endmodule

// File: rtl/twsh_flags.sv
module twsh_flags (
    input  logic clk,
    input  logic rst,
    input  logic start_evt,
    input  logic scl_low,
    input  logic cnt_ovf,
    input  logic clr_start,
    input  logic clr_ovf,
    input  logic ovf_hold_en,
    output logic start_flag,
    output logic ovf_flag,
    output logic hold_req
);
    logic start_hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_flag   <= 1'b0;
            ovf_flag     <= 1'b0;
            start_hold_q <= 1'b0;
        end else begin
            // set has priority over the software clear
            if (start_evt)      start_flag <= 1'b1;
            else if (clr_start) start_flag <= 1'b0;

            if (cnt_ovf)        ovf_flag <= 1'b1;
            else if (clr_ovf)   ovf_flag <= 1'b0;

            // start hold engages once the master has pulled the clock low
            if (clr_start)                    start_hold_q <= 1'b0;
            else if (start_flag && scl_low)   start_hold_q <= 1'b1;
        end
    end

    assign hold_req = start_hold_q | (ovf_flag & ovf_hold_en);
endmodule

// File: rtl/twsh_top.sv
module twsh_top
    import twsh_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sda_in,
    input  logic scl_in,
    input  logic shift_msb,
    input  logic scl_data_low,
    input  logic cnt_ovf,
    input  logic clr_start,
    input  logic clr_ovf,
    input  logic start_ie,
    input  logic ovf_ie,
    input  logic ovf_hold_en,
    output logic start_flag,
    output logic ovf_flag,
    output logic irq,
    output logic cnt_reset,
    output logic scl_pull_low,
    output logic sda_pull_low
);
    bus_lines_t raw_lines;
    bus_lines_t sync_lines;
    logic       start_evt;
    logic       hold_req;

    assign raw_lines = '{sda: sda_in, scl: scl_in};

    twsh_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_lines),
        .synced (sync_lines)
    );

    twsh_start_det i_det (
        .clk       (clk),
        .rst       (rst),
        .synced    (sync_lines),
        .start_evt (start_evt)
    );

    twsh_flags i_flags (
        .clk         (clk),
        .rst         (rst),
        .start_evt   (start_evt),
        .scl_low     (~sync_lines.scl),
        .cnt_ovf     (cnt_ovf),
        .clr_start   (clr_start),
        .clr_ovf     (clr_ovf),
        .ovf_hold_en (ovf_hold_en),
        .start_flag  (start_flag),
        .ovf_flag    (ovf_flag),
        .hold_req    (hold_req)
    );

    assign cnt_reset    = start_evt;
    // wired-AND on the bus: any low request wins
    assign scl_pull_low = hold_req | scl_data_low;
    assign sda_pull_low = ~shift_msb;
    assign irq          = (start_flag & start_ie) | (ovf_flag & ovf_ie);
endmodule

// File: rtl/twsh_checker.sv
module twsh_checker (
    input logic clk,
    input logic rst,
    input logic cnt_reset,
    input logic clr_start,
    input logic cnt_ovf,
    input logic clr_ovf,
    input logic ovf_hold_en,
    input logic scl_data_low,
    input logic start_ie,
    input logic ovf_ie,
    input logic start_flag,
    input logic ovf_flag,
    input logic irq,
    input logic scl_pull_low
);
    a_r2_reset_sets_flag: assert property (@(posedge clk) disable iff (rst)
        cnt_reset |=> start_flag);

    a_r3_clear_drops_flag: assert property (@(posedge clk) disable iff (rst)
        (clr_start && !cnt_reset) |=> !start_flag);

    a_r5_ovf_sets_flag: assert property (@(posedge clk) disable iff (rst)
        cnt_ovf |=> ovf_flag);

    a_r5_ovf_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_ovf && !cnt_ovf) |=> !ovf_flag);

    a_r6_ovf_holds: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && ovf_hold_en) |-> scl_pull_low);

    a_r7_no_irq_idle: assert property (@(posedge clk) disable iff (rst)
        (!start_flag && !ovf_flag) |-> !irq);

    a_r7_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (!start_ie && !ovf_ie) |-> !irq);

    a_r8_release_idle: assert property (@(posedge clk) disable iff (rst)
        (!start_flag && !ovf_flag && !scl_data_low) |-> !scl_pull_low);
endmodule

bind twsh_top twsh_checker i_checker (
    .clk          (clk),
    .rst          (rst),
    .cnt_reset    (cnt_reset),
    .clr_start    (clr_start),
    .cnt_ovf      (cnt_ovf),
    .clr_ovf      (clr_ovf),
    .ovf_hold_en  (ovf_hold_en),
    .scl_data_low (scl_data_low),
    .start_ie     (start_ie),
    .ovf_ie       (ovf_ie),
    .start_flag   (start_flag),
    .ovf_flag     (ovf_flag),
    .irq          (irq),
    .scl_pull_low (scl_pull_low)
);

// File: tb/test_twsh_top.sv
module test_twsh_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sda_in = 1'b1, scl_in = 1'b1, shift_msb = 1'b1, scl_data_low = 1'b0;
    logic cnt_ovf = 1'b0, clr_start = 1'b0, clr_ovf = 1'b0;
    logic start_ie = 1'b0, ovf_ie = 1'b0, ovf_hold_en = 1'b0;
    logic start_flag, ovf_flag, irq, cnt_reset, scl_pull_low, sda_pull_low;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    twsh_top i_twsh_top (
        .clk(clk), .rst(rst), .sda_in(sda_in), .scl_in(scl_in),
        .shift_msb(shift_msb), .scl_data_low(scl_data_low), .cnt_ovf(cnt_ovf),
        .clr_start(clr_start), .clr_ovf(clr_ovf), .start_ie(start_ie),
        .ovf_ie(ovf_ie), .ovf_hold_en(ovf_hold_en), .start_flag(start_flag),
        .ovf_flag(ovf_flag), .irq(irq), .cnt_reset(cnt_reset),
        .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic exp_irq(input logic sf, input logic of, input logic sie, input logic oie);
        return (sf & sie) | (of & oie);
    endfunction

    // one-cycle pulse of the clear strobe, driven between edges
    task automatic pulse_clr_start();
        clr_start = 1'b1; wait_n(1); clr_start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic m_flag, m_hold, m_sda;
        void'($urandom(32'd1234));
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        // reset state
        chk("R7 reset irq", irq, 1'b0);
        chk("R1 reset start_flag", start_flag, 1'b0);
        chk("R5 reset ovf_flag", ovf_flag, 1'b0);
        chk("R8 reset scl_pull_low", scl_pull_low, 1'b0);

        // R9 data line drive follows the MSB
        shift_msb = 1'b0; #1;
        chk("R9 msb0 pulls sda", sda_pull_low, 1'b1);
        shift_msb = 1'b1; #1;
        chk("R9 msb1 releases sda", sda_pull_low, 1'b0);

        // R1/R2 start timing
        start_ie = 1'b1;
        sda_in = 1'b0;               // before edge k
        wait_n(1);                   // after edge k
        chk("R2 no pulse yet", cnt_reset, 1'b0);
        wait_n(1);                   // after edge k+1
        chk("R2 counter clear pulse", cnt_reset, 1'b1);
        chk("R1 flag not yet", start_flag, 1'b0);
        wait_n(1);                   // after edge k+2
        chk("R2 pulse one cycle", cnt_reset, 1'b0);
        chk("R1 start flag set", start_flag, 1'b1);
        chk("R7 start irq", irq, exp_irq(1'b1, 1'b0, 1'b1, 1'b0));
        // R4: clock still high, no hold
        wait_n(3);
        chk("R4 no hold while scl high", scl_pull_low, 1'b0);
        scl_in = 1'b0;
        wait_n(4);
        chk("R4 hold after scl low", scl_pull_low, 1'b1);
        scl_in = 1'b1;               // master releases, hold still on
        wait_n(4);
        chk("R4 hold persists", scl_pull_low, 1'b1);
        // R3 clear releases
        pulse_clr_start();
        chk("R3 flag cleared", start_flag, 1'b0);
        chk("R3 hold released", scl_pull_low, 1'b0);
        chk("R7 irq dropped", irq, 1'b0);

        // R10: stop-like rise and fall with clock low
        sda_in = 1'b1; wait_n(5);
        chk("R10 rising sda no start", start_flag, 1'b0);
        scl_in = 1'b0; wait_n(4);
        sda_in = 1'b0; wait_n(5);
        chk("R10 fall with scl low no start", start_flag, 1'b0);
        sda_in = 1'b1; wait_n(4);
        scl_in = 1'b1; wait_n(4);

        // R3 collision: clear in the cycle of the start pulse
        sda_in = 1'b0;
        wait_n(2);
        chk("R2 pulse before collision", cnt_reset, 1'b1);
        pulse_clr_start();
        chk("R3 set wins over clear", start_flag, 1'b1);
        pulse_clr_start();
        sda_in = 1'b1; wait_n(4);

        // R5/R6 overflow
        ovf_ie = 1'b1; ovf_hold_en = 1'b1; start_ie = 1'b0;
        cnt_ovf = 1'b1; wait_n(1); cnt_ovf = 1'b0;
        chk("R5 ovf flag set", ovf_flag, 1'b1);
        chk("R6 ovf hold", scl_pull_low, 1'b1);
        chk("R7 ovf irq", irq, exp_irq(1'b0, 1'b1, 1'b0, 1'b1));
        ovf_hold_en = 1'b0; #1;
        chk("R6 hold disabled", scl_pull_low, 1'b0);
        ovf_ie = 1'b0; #1;
        chk("R7 ovf irq masked", irq, 1'b0);
        // R5 collision
        cnt_ovf = 1'b1; clr_ovf = 1'b1; wait_n(1); cnt_ovf = 1'b0;
        chk("R5 set wins over clear", ovf_flag, 1'b1);
        wait_n(1); clr_ovf = 1'b0;
        chk("R5 flag cleared", ovf_flag, 1'b0);

        // R8 data-path pull joins the hold
        scl_data_low = 1'b1; #1;
        chk("R8 data pull passes", scl_pull_low, 1'b1);
        scl_data_low = 1'b0; #1;
        chk("R8 data pull released", scl_pull_low, 1'b0);

        // random line sequence against a step model
        start_ie = 1'b1;
        m_flag = 1'b0; m_hold = 1'b0; m_sda = sda_in;
        for (int s = 0; s < 300; s++) begin
            logic nsda, nscl;
            nsda = 1'($urandom_range(0, 1));
            nscl = 1'($urandom_range(0, 1));
            sda_in = nsda; scl_in = nscl;
            if (m_sda && !nsda && nscl) m_flag = 1'b1;
            m_sda = nsda;
            wait_n(6);
            if (m_flag && !nscl) m_hold = 1'b1;
            wait_n(1);
            chk("R1 random start flag", start_flag, m_flag);
            chk("R4 random hold", scl_pull_low, m_hold);
            chk("R7 random irq", irq, m_flag);
            if ($urandom_range(0, 4) == 0) begin
                pulse_clr_start();
                m_flag = 1'b0; m_hold = 1'b0;
                chk("R3 random clear", start_flag, 1'b0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule